// File: doc/BRIEF.md
# Fixed and variable rotate unit

This combinational unit sits beside the shifter of a 64-bit integer core. It looks at a full 32-bit instruction word and recognises five right-rotate operations. They share the special major opcode (all zero) and the function codes of the shift family. A rotate is told apart from its plain shift twin by a 1 in a field that a shift leaves at zero. The immediate forms put 00001 in the rs field (bits 25..21). The register forms put 00001 in the sa field (bits 10..6).

Two of the forms work on a 32-bit word. They rotate the low half of the rt operand and sign-extend the 32-bit result to 64 bits. The other three rotate the whole 64-bit rt operand. The amount comes from one of three places: the 5-bit sa field, the low bits of the rs operand, or the sa field with 32 added, so that an immediate doubleword rotate can reach amounts 32 to 63. The core uses `is_rotate` to pick this unit's `result` over its other execution units. When the word is not a rotate, `result` is zero.

Top module: `rot_unit`

## Requirements
- R1: `is_rotate` is 1 only when bits 31..26 of `instr_word` are 000000 and the word carries one of the five encodings in R2 to R6. For every other word it is 0 and `result` is all zeros.
- R2: rs field 00001 with function 000010 rotates `rt_val[31:0]` right by the sa field (bits 10..6).
- R3: sa field 00001 with function 000110 rotates `rt_val[31:0]` right by `rs_val[4:0]`. Bits 63..5 of `rs_val` have no effect.
- R4: rs field 00001 with function 111010 rotates all 64 bits of `rt_val` right by the sa field.
- R5: rs field 00001 with function 111110 rotates all 64 bits of `rt_val` right by the sa field plus 32.
- R6: sa field 00001 with function 010110 rotates all 64 bits of `rt_val` right by `rs_val[5:0]`. Bits 63..6 of `rs_val` have no effect.
- R7: For the two 32-bit forms, `result[63:32]` repeats bit 31 of the rotated word, and `rt_val[63:32]` has no effect.
- R8: A rotate amount of zero returns the operand unchanged. For the 32-bit forms this is the sign-extended low word.
- R9: The five function codes with the marker field at 00000 are plain shifts. These words, and any marker value other than 00001, give `is_rotate` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_word | input | 32 | Instruction word to decode |
| rt_val | input | 64 | Operand that is rotated |
| rs_val | input | 64 | Source of the amount for the register forms |
| result | output | 64 | Rotated value, zero when not a rotate |
| is_rotate | output | 1 | High when the word is one of the five rotates |

## Verification
The bench checks every amount from 0 to 63 on every form against a rotate built in the bench from two shifts and an OR.
- Amount zero needs care: a design that shifts by the full width there would return zero instead of the operand.
- The register forms get rs values with junk in the upper bits. A design that uses too many amount bits would rotate by the wrong distance.
- A rotate by amount 33 in the 32-bit register form must equal a rotate by 1.
- The 32-bit forms are fed operands whose upper halves disagree with bit 31. A design that passes the high half through or zero-extends would then show a wrong upper word.
- The shift twins and near-miss marker values are driven. A decoder that tests only the function code would claim them as rotates.

// File: rtl/rot_pkg.sv
// Shared constants and types for the rotate unit.
// Assumes the classic 32-bit instruction layout with a 6-bit major opcode
// in bits 31..26 and a 6-bit function code in bits 5..0.
package rot_pkg;

    localparam int XLEN   = 64;
    localparam int WLEN   = 32;
    localparam int XSHW   = $clog2(XLEN);
    localparam int WSHW   = $clog2(WLEN);
    localparam int FLDW   = 5;

    localparam logic [5:0] OPC_SPECIAL   = 6'b000000;
    localparam logic [4:0] MARK_ROTATE   = 5'b00001;

    localparam logic [5:0] FN_W_IMM      = 6'b000010;
    localparam logic [5:0] FN_W_VAR      = 6'b000110;
    localparam logic [5:0] FN_D_IMM      = 6'b111010;
    localparam logic [5:0] FN_D_IMM_HI   = 6'b111110;
    localparam logic [5:0] FN_D_VAR      = 6'b010110;

    typedef enum logic [2:0] {
        RK_NONE     = 3'd0,
        RK_W_IMM    = 3'd1,
        RK_W_VAR    = 3'd2,
        RK_D_IMM    = 3'd3,
        RK_D_IMM_HI = 3'd4,
        RK_D_VAR    = 3'd5
    } rot_kind_e;

endpackage

// File: rtl/rot_decode.sv
// Decoder for the rotate instructions.
// Recognises the five rotate encodings, reports which one was seen and
// forms the 6-bit rotate amount. Assumes nothing about the rt and rd fields.
module rot_decode
    import rot_pkg::*;
(
    input  logic [31:0]     instr_word,
    input  logic [XSHW-1:0] rs_low,
    output rot_kind_e       kind,
    output logic [XSHW-1:0] amount
);

    logic [5:0]      opc;
    logic [FLDW-1:0] rs_fld;
    logic [FLDW-1:0] sa_fld;
    logic [5:0]      fn;
    logic            imm_mark;
    logic            var_mark;
    logic            unused_fields;

    assign opc           = instr_word[31:26];
    assign rs_fld        = instr_word[25:21];
    assign sa_fld        = instr_word[10:6];
    assign fn            = instr_word[5:0];
    assign unused_fields = ^instr_word[20:11];

    // Marker tests: an immediate rotate flags its rs field, a register rotate its sa field.
    assign imm_mark = (opc == OPC_SPECIAL) && (rs_fld == MARK_ROTATE);
    assign var_mark = (opc == OPC_SPECIAL) && (sa_fld == MARK_ROTATE);

    // Pick the rotate kind from the function code and the marker.
    always_comb begin
        kind = RK_NONE;
        unique case (fn)
            FN_W_IMM:    if (imm_mark) kind = RK_W_IMM;
            FN_D_IMM:    if (imm_mark) kind = RK_D_IMM;
            FN_D_IMM_HI: if (imm_mark) kind = RK_D_IMM_HI;
            FN_W_VAR:    if (var_mark) kind = RK_W_VAR;
            FN_D_VAR:    if (var_mark) kind = RK_D_VAR;
            default:     kind = RK_NONE;
        endcase
    end

    // Form the amount for the selected kind.
    always_comb begin
        case (kind)
            RK_W_IMM,
            RK_D_IMM:    amount = {1'b0, sa_fld};
            RK_D_IMM_HI: amount = {1'b1, sa_fld};
            RK_W_VAR:    amount = {1'b0, rs_low[WSHW-1:0]};
            RK_D_VAR:    amount = rs_low;
            default:     amount = '0;
        endcase
    end

    // Guards on the decoder outputs.
    always_comb begin
        if (kind == RK_D_IMM_HI)
            assert_hi_amount_R5: assert (amount >= XSHW'(WLEN));
        if (kind == RK_W_VAR || kind == RK_W_IMM)
            assert_word_amount_R3: assert (amount < XSHW'(WLEN));
        if (rs_fld == 5'b00000 && (fn == FN_W_IMM || fn == FN_D_IMM || fn == FN_D_IMM_HI))
            assert_shift_twin_R9: assert (kind == RK_NONE);
        if (sa_fld == 5'b00000 && (fn == FN_W_VAR || fn == FN_D_VAR))
            assert_var_shift_twin_R9: assert (kind == RK_NONE);
    end

endmodule

// File: rtl/rot_barrel.sv
// Logarithmic right-rotator of parameterised width.
// Each stage rotates by a power of two when its amount bit is set.
// Assumes WIDTH is a power of two.
module rot_barrel #(
    parameter int WIDTH = 64,
    localparam int SW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] din,
    input  logic [SW-1:0]    amt,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] stg [0:SW];

    assign stg[0] = din;

    for (genvar s = 0; s < SW; s++) begin : g_stage
        localparam int STEP = 1 << s;
        // Rotate right by STEP when amount bit s is set.
        always_comb begin
            if (amt[s])
                stg[s+1] = {stg[s][STEP-1:0], stg[s][WIDTH-1:STEP]};
            else
                stg[s+1] = stg[s];
        end
    end

    assign dout = stg[SW];

    // A rotate keeps every bit, and a zero amount keeps their places.
    always_comb begin
        assert_bits_kept_R4: assert ($countones(dout) == $countones(din));
        if (amt == '0)
            assert_zero_amount_R8: assert (dout == din);
    end

endmodule

// File: rtl/rot_unit.sv
// Top of the rotate unit.
// Decodes the instruction, runs a 32-bit and a 64-bit rotator side by side
// and selects the result, sign-extending the 32-bit forms. Purely combinational.
module rot_unit
    import rot_pkg::*;
(
    input  logic [31:0]     instr_word,
    input  logic [XLEN-1:0] rt_val,
    input  logic [XLEN-1:0] rs_val,
    output logic [XLEN-1:0] result,
    output logic            is_rotate
);

    rot_kind_e       kind;
    logic [XSHW-1:0] amount;
    logic [WLEN-1:0] word_rot;
    logic [XLEN-1:0] dword_rot;
    logic            unused_rs_hi;

    assign unused_rs_hi = ^rs_val[XLEN-1:XSHW];

    rot_decode u_decode (
        .instr_word (instr_word),
        .rs_low     (rs_val[XSHW-1:0]),
        .kind       (kind),
        .amount     (amount)
    );

    rot_barrel #(.WIDTH(WLEN)) u_word (
        .din  (rt_val[WLEN-1:0]),
        .amt  (amount[WSHW-1:0]),
        .dout (word_rot)
    );

    rot_barrel #(.WIDTH(XLEN)) u_dword (
        .din  (rt_val),
        .amt  (amount),
        .dout (dword_rot)
    );

    // Select and widen the result for the decoded kind.
    always_comb begin
        is_rotate = 1'b1;
        case (kind)
            RK_W_IMM, RK_W_VAR:
                result = {{(XLEN-WLEN){word_rot[WLEN-1]}}, word_rot};
            RK_D_IMM, RK_D_IMM_HI, RK_D_VAR:
                result = dword_rot;
            default: begin
                result    = '0;
                is_rotate = 1'b0;
            end
        endcase
    end

    // Port-level guards.
    always_comb begin
        if (is_rotate)
            assert_special_opcode_R1: assert (instr_word[31:26] == OPC_SPECIAL);
        if (kind == RK_W_IMM || kind == RK_W_VAR)
            assert_sign_extend_R7: assert (result[XLEN-1:WLEN] == {(XLEN-WLEN){result[WLEN-1]}});
    end

endmodule

// File: tb/rot_unit_tb.sv
// Self-checking bench: sweeps every amount of every rotate form and the
// non-rotate twins, comparing against a rotate made from shifts and an OR.
module rot_unit_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk;
    logic        rst_n;
    logic [31:0] instr_word;
    logic [63:0] rt_val;
    logic [63:0] rs_val;
    logic [63:0] result;
    logic        is_rotate;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    rot_unit dut_i (
        .instr_word (instr_word),
        .rt_val     (rt_val),
        .rs_val     (rs_val),
        .result     (result),
        .is_rotate  (is_rotate)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mk(input logic [4:0] rsf, input logic [4:0] saf, input logic [5:0] fn);
        return {6'b000000, rsf, 5'd7, 5'd3, saf, fn};
    endfunction

    function automatic logic [63:0] ref_w(input logic [63:0] v, input int a);
        logic [31:0] x;
        logic [31:0] r;
        x = v[31:0];
        r = (x >> a) | (x << (32 - a));
        if (a == 0) r = x;
        return {{32{r[31]}}, r};
    endfunction

    function automatic logic [63:0] ref_d(input logic [63:0] v, input int a);
        if (a == 0) return v;
        return (v >> a) | (v << (64 - a));
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic [31:0] iw, input logic [63:0] rt, input logic [63:0] rs);
        @(posedge clk);
        instr_word <= iw;
        rt_val     <= rt;
        rs_val     <= rs;
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] ops [0:1];
        ops[0] = 64'h0123_4567_A5C3_0F1E;
        ops[1] = 64'hFEDC_BA98_1234_5671;
        rst_n      = 1'b0;
        instr_word = 32'h0;
        rt_val     = 64'h0;
        rs_val     = 64'h0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: a zero word is not a rotate
        check("R1 idle flag", {63'b0, is_rotate}, 64'b0);
        check("R1 idle result", result, 64'b0);

        for (int k = 0; k < 2; k++) begin
            for (int a = 0; a < 32; a++) begin
                // R2 and R7: immediate word rotate, upper rt bits ignored
                apply(mk(5'b00001, a[4:0], 6'b000010), ops[k], 64'h0);
                check(a == 0 ? "R8 R2 word imm" : "R2 R7 word imm", result, ref_w(ops[k], a));
                check("R1 flag word imm", {63'b0, is_rotate}, 64'd1);
                // R4: immediate doubleword rotate
                apply(mk(5'b00001, a[4:0], 6'b111010), ops[k], 64'h0);
                check(a == 0 ? "R8 R4 dword imm" : "R4 dword imm", result, ref_d(ops[k], a));
                // R5: immediate doubleword rotate plus 32
                apply(mk(5'b00001, a[4:0], 6'b111110), ops[k], 64'h0);
                check("R5 dword imm plus 32", result, ref_d(ops[k], a + 32));
            end
            for (int a = 0; a < 64; a++) begin
                // R3: register word rotate, only rs[4:0] counts
                apply(mk(5'd9, 5'b00001, 6'b000110), ops[k], {58'h2AB_CDEF_0123_4567, a[5:0]});
                check("R3 R7 word var", result, ref_w(ops[k], a % 32));
                // R6: register doubleword rotate, only rs[5:0] counts
                apply(mk(5'd9, 5'b00001, 6'b010110), ops[k], {58'h3FF_FFFF_FFFF_FFFF, a[5:0]});
                check(a == 0 ? "R8 R6 dword var" : "R6 dword var", result, ref_d(ops[k], a));
                check("R1 flag dword var", {63'b0, is_rotate}, 64'd1);
            end
        end

        // R9: shift twins with the marker at zero, and wrong marker values
        apply(mk(5'b00000, 5'd4, 6'b000010), ops[0], 64'h5);
        check("R9 word imm twin flag", {63'b0, is_rotate}, 64'b0);
        check("R9 word imm twin result", result, 64'b0);
        apply(mk(5'b00000, 5'd4, 6'b111010), ops[0], 64'h5);
        check("R9 dword imm twin flag", {63'b0, is_rotate}, 64'b0);
        apply(mk(5'b00000, 5'd4, 6'b111110), ops[0], 64'h5);
        check("R9 dword hi twin flag", {63'b0, is_rotate}, 64'b0);
        apply(mk(5'd2, 5'b00000, 6'b000110), ops[0], 64'h5);
        check("R9 word var twin flag", {63'b0, is_rotate}, 64'b0);
        apply(mk(5'd2, 5'b00000, 6'b010110), ops[0], 64'h5);
        check("R9 dword var twin flag", {63'b0, is_rotate}, 64'b0);
        check("R9 dword var twin result", result, 64'b0);
        apply(mk(5'b00010, 5'd4, 6'b000010), ops[0], 64'h5);
        check("R9 marker 00010 flag", {63'b0, is_rotate}, 64'b0);
        apply(mk(5'd2, 5'b00011, 6'b010110), ops[0], 64'h5);
        check("R9 marker 00011 flag", {63'b0, is_rotate}, 64'b0);
        // R1: non-special opcode carrying a rotate pattern
        apply(mk(5'b00001, 5'd4, 6'b000010) | 32'h0400_0000, ops[0], 64'h5);
        check("R1 opcode flag", {63'b0, is_rotate}, 64'b0);
        check("R1 opcode result", result, 64'b0);
        // R1: unrelated function code with both markers set
        apply(mk(5'b00001, 5'b00001, 6'b100001), ops[0], 64'h5);
        check("R1 other funct flag", {63'b0, is_rotate}, 64'b0);

        finish_run();
    end

endmodule